// File: doc/BRIEF.md
# Processor Status Word with Banked Stack Pointer

This block holds the processor status word and the stack-pointer storage that depends on it. The status word is made of three parts, each of which can also be accessed alone: a 6-bit flag byte, a 3-bit system-control field and a 5-bit interrupt level mask. Beside the status word the block keeps one live stack pointer plus two banked copies, one for the user stack and one for the system stack. The flag byte contains a stack-select bit. Changing that bit exchanges the live pointer with the bank that belongs to the new mode.

Every register has a write port, and the status word has one for the whole word and one for each part. All stack views can be written: the live pointer, the system-bank view and the user-bank view. A bank view that names the stack currently in use is routed to the live pointer. Read data is a continuous view of the stored state, so a write made at one clock edge can be read back right after that edge. The mask has a privilege floor. Once the mask reaches the upper half of its range, a write cannot bring it back into the lower half.

Top module: `status_stack_bank`

## Requirements
- R1: Synchronous active-high reset clears every field, the mask and all three stack registers to zero.
- R2: The flag byte (read as 8 bits) holds carry at bit 0, overflow at bit 1, zero at bit 2, negative at bit 3, interrupt enable at bit 4 and stack select at bit 5. A write keeps the low 6 bits and bits 7:6 read as zero.
- R3: The system-control field (read as 8 bits) holds trace at bit 0 and two debug bits at bits 1 and 2. A write keeps the low 3 bits and the rest read as zero.
- R4: The 32-bit status word has the flag byte at bits 7:0, system control at bits 10:8 and the mask at bits 20:16. All other bits read zero. A status-word write loads all three parts from those positions.
- R5: The mask port keeps the low 5 bits of its 8-bit write data and reads back zero-extended. When the stored mask is 16 or more and the written mask value is below 16, 16 is added before it is stored. Otherwise the value is stored as written. This applies equally to status-word writes.
- R6: A write that changes stack select from 0 to 1 copies the live pointer into the system bank and loads the live pointer from the user bank.
- R7: A write that changes stack select from 1 to 0 copies the live pointer into the user bank and loads the live pointer from the system bank.
- R8: Writing stack select with its current value moves no stack register.
- R9: With stack select 0, system-bank reads and writes reach the live pointer. With stack select 1, user-bank reads and writes reach the live pointer. Otherwise each bank view reaches its own stored copy.
- R10: When a status-word write and any part write occur in the same cycle, only the status-word write takes effect.
- R11: Stack writes in a cycle are routed using the stack select from before that cycle's write. A live-pointer write overrides a bank-view write aliased to the live pointer. An exchange in the same cycle then moves the values as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psw_we | input | 1 | Whole status-word write enable |
| psw_wdata | input | 32 | Status-word write data |
| psw_rdata | output | 32 | Status-word read data |
| cc_we | input | 1 | Flag byte write enable |
| cc_wdata | input | 8 | Flag byte write data |
| cc_rdata | output | 8 | Flag byte read data |
| sc_we | input | 1 | System-control write enable |
| sc_wdata | input | 8 | System-control write data |
| sc_rdata | output | 8 | System-control read data |
| im_we | input | 1 | Interrupt mask write enable |
| im_wdata | input | 8 | Interrupt mask write data |
| im_rdata | output | 8 | Interrupt mask read data |
| ssp_we | input | 1 | System stack view write enable |
| ssp_wdata | input | SP_W | System stack view write data |
| ssp_rdata | output | SP_W | System stack view read data |
| usp_we | input | 1 | User stack view write enable |
| usp_wdata | input | SP_W | User stack view write data |
| usp_rdata | output | SP_W | User stack view read data |
| sp_we | input | 1 | Live stack pointer write enable |
| sp_wdata | input | SP_W | Live stack pointer write data |
| sp_rdata | output | SP_W | Live stack pointer read data |

## Verification
Every stored bit can be read on some port the cycle after it is written, so a wrong internal state shows up at the first read after the faulty edge. A missed or reversed exchange is exposed by the banked views. After a mode change the bank that should now mirror the live pointer reads a different value from it, or the copy that should hold the old live value reads something else. A mask written without the floor becomes visible as soon as bit 4 of the mask clears while writes alone are being applied. A wrong write priority corrupts the part that lost the arbitration, and the fault appears at the next status-word read.

// File: rtl/psb_pkg.sv
package psb_pkg;
  localparam int PSW_W   = 32;
  localparam int SUB_W   = 8;
  localparam int CC_W    = 6;
  localparam int SC_W    = 3;
  localparam int IM_W    = 5;
  localparam int SC_LSB  = 8;
  localparam int IM_LSB  = 16;
  localparam int SEL_BIT = 5;
  localparam int IM_FLOOR_BIT = IM_W - 1;

  typedef struct packed {
    logic            cc_we;
    logic [CC_W-1:0] cc;
    logic            sc_we;
    logic [SC_W-1:0] sc;
    logic            im_we;
    logic [IM_W-1:0] im;
  } psb_req_t;

  function automatic logic [PSW_W-1:0] psw_pack(input logic [CC_W-1:0] cc,
                                                 input logic [SC_W-1:0] sc,
                                                 input logic [IM_W-1:0] im);
    logic [PSW_W-1:0] w;
    w = '0;
    w[CC_W-1:0]            = cc;
    w[SC_LSB +: SC_W]      = sc;
    w[IM_LSB +: IM_W]      = im;
    return w;
  endfunction
endpackage

// File: rtl/psb_wr_arb.sv
module psb_wr_arb
  import psb_pkg::*;
(
  input  logic             psw_we,
  input  logic [PSW_W-1:0] psw_wdata,
  input  logic             cc_we,
  input  logic [SUB_W-1:0] cc_wdata,
  input  logic             sc_we,
  input  logic [SUB_W-1:0] sc_wdata,
  input  logic             im_we,
  input  logic [SUB_W-1:0] im_wdata,
  output psb_req_t         req
);
  wire unused_wdata_bits = ^{psw_wdata[PSW_W-1:IM_LSB+IM_W],
                             psw_wdata[IM_LSB-1:SC_LSB+SC_W],
                             psw_wdata[SC_LSB-1:CC_W],
                             cc_wdata[SUB_W-1:CC_W],
                             sc_wdata[SUB_W-1:SC_W],
                             im_wdata[SUB_W-1:IM_W]};

  always_comb begin
    if (psw_we) begin
      req.cc_we = 1'b1;
      req.cc    = psw_wdata[CC_W-1:0];
      req.sc_we = 1'b1;
      req.sc    = psw_wdata[SC_LSB +: SC_W];
      req.im_we = 1'b1;
      req.im    = psw_wdata[IM_LSB +: IM_W];
    end else begin
      req.cc_we = cc_we;
      req.cc    = cc_wdata[CC_W-1:0];
      req.sc_we = sc_we;
      req.sc    = sc_wdata[SC_W-1:0];
      req.im_we = im_we;
      req.im    = im_wdata[IM_W-1:0];
    end
  end
endmodule

// File: rtl/psb_flags.sv
module psb_flags
  import psb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  psb_req_t        req,
  output logic [CC_W-1:0] cc_q,
  output logic [SC_W-1:0] sc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q <= '0;
      sc_q <= '0;
    end else begin
      if (req.cc_we) cc_q <= req.cc;
      if (req.sc_we) sc_q <= req.sc;
    end
  end
endmodule

// File: rtl/psb_im_clamp.sv
module psb_im_clamp
  import psb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IM_W-1:0] wdata,
  output logic [IM_W-1:0] im_q
);
  logic [IM_W-1:0] im_next;

  always_comb begin
    im_next = wdata;
    if (im_q[IM_FLOOR_BIT] && !wdata[IM_FLOOR_BIT])
      im_next[IM_FLOOR_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)     im_q <= '0;
    else if (we) im_q <= im_next;
  end
endmodule

// File: rtl/psb_stack_bank.sv
module psb_stack_bank #(
  parameter int SP_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_cur,
  input  logic            sel_nxt,
  input  logic            ssp_we,
  input  logic [SP_W-1:0] ssp_wdata,
  input  logic            usp_we,
  input  logic [SP_W-1:0] usp_wdata,
  input  logic            sp_we,
  input  logic [SP_W-1:0] sp_wdata,
  output logic [SP_W-1:0] live_q,
  output logic [SP_W-1:0] ubank_q,
  output logic [SP_W-1:0] sbank_q
);
  logic [SP_W-1:0] live_w, ubank_w, sbank_w;
  logic [SP_W-1:0] live_n, ubank_n, sbank_n;

  always_comb begin
    live_w  = live_q;
    ubank_w = ubank_q;
    sbank_w = sbank_q;
    if (usp_we) begin
      if (sel_cur) live_w  = usp_wdata;
      else         ubank_w = usp_wdata;
    end
    if (ssp_we) begin
      if (!sel_cur) live_w  = ssp_wdata;
      else          sbank_w = ssp_wdata;
    end
    if (sp_we) live_w = sp_wdata;

    live_n  = live_w;
    ubank_n = ubank_w;
    sbank_n = sbank_w;
    if (sel_cur && !sel_nxt) begin
      ubank_n = live_w;
      live_n  = sbank_w;
    end else if (!sel_cur && sel_nxt) begin
      sbank_n = live_w;
      live_n  = ubank_w;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      ubank_q <= '0;
      sbank_q <= '0;
    end else begin
      live_q  <= live_n;
      ubank_q <= ubank_n;
      sbank_q <= sbank_n;
    end
  end
endmodule

// File: rtl/status_stack_bank.sv
module status_stack_bank
  import psb_pkg::*;
#(
  parameter int SP_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             psw_we,
  input  logic [PSW_W-1:0] psw_wdata,
  output logic [PSW_W-1:0] psw_rdata,
  input  logic             cc_we,
  input  logic [SUB_W-1:0] cc_wdata,
  output logic [SUB_W-1:0] cc_rdata,
  input  logic             sc_we,
  input  logic [SUB_W-1:0] sc_wdata,
  output logic [SUB_W-1:0] sc_rdata,
  input  logic             im_we,
  input  logic [SUB_W-1:0] im_wdata,
  output logic [SUB_W-1:0] im_rdata,
  input  logic             ssp_we,
  input  logic [SP_W-1:0]  ssp_wdata,
  output logic [SP_W-1:0]  ssp_rdata,
  input  logic             usp_we,
  input  logic [SP_W-1:0]  usp_wdata,
  output logic [SP_W-1:0]  usp_rdata,
  input  logic             sp_we,
  input  logic [SP_W-1:0]  sp_wdata,
  output logic [SP_W-1:0]  sp_rdata
);
  psb_req_t        req;
  logic [CC_W-1:0] cc_q;
  logic [SC_W-1:0] sc_q;
  logic [IM_W-1:0] im_q;
  logic [SP_W-1:0] live_q, ubank_q, sbank_q;
  logic            sel_cur, sel_nxt;

  psb_wr_arb u_arb (
    .psw_we(psw_we), .psw_wdata(psw_wdata),
    .cc_we(cc_we), .cc_wdata(cc_wdata),
    .sc_we(sc_we), .sc_wdata(sc_wdata),
    .im_we(im_we), .im_wdata(im_wdata),
    .req(req)
  );

  psb_flags u_flags (
    .clk(clk), .rst(rst), .req(req), .cc_q(cc_q), .sc_q(sc_q)
  );

  psb_im_clamp u_im (
    .clk(clk), .rst(rst), .we(req.im_we), .wdata(req.im), .im_q(im_q)
  );

  assign sel_cur = cc_q[SEL_BIT];
  assign sel_nxt = req.cc_we ? req.cc[SEL_BIT] : sel_cur;

  psb_stack_bank #(.SP_W(SP_W)) u_stack (
    .clk(clk), .rst(rst),
    .sel_cur(sel_cur), .sel_nxt(sel_nxt),
    .ssp_we(ssp_we), .ssp_wdata(ssp_wdata),
    .usp_we(usp_we), .usp_wdata(usp_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata),
    .live_q(live_q), .ubank_q(ubank_q), .sbank_q(sbank_q)
  );

  assign psw_rdata = psw_pack(cc_q, sc_q, im_q);
  assign cc_rdata  = {{(SUB_W-CC_W){1'b0}}, cc_q};
  assign sc_rdata  = {{(SUB_W-SC_W){1'b0}}, sc_q};
  assign im_rdata  = {{(SUB_W-IM_W){1'b0}}, im_q};
  assign sp_rdata  = live_q;
  assign ssp_rdata = sel_cur ? sbank_q : live_q;
  assign usp_rdata = sel_cur ? live_q  : ubank_q;
endmodule

// File: rtl/status_stack_bank_chk.sv
module status_stack_bank_chk #(
  parameter int SP_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            psw_we,
  input logic            sc_we,
  input logic            ssp_we,
  input logic            usp_we,
  input logic            sp_we,
  input logic [7:0]      cc_rdata,
  input logic [7:0]      sc_rdata,
  input logic [7:0]      im_rdata,
  input logic [SP_W-1:0] ssp_rdata,
  input logic [SP_W-1:0] usp_rdata,
  input logic [SP_W-1:0] sp_rdata
);
  logic stk_wr;
  assign stk_wr = ssp_we | usp_we | sp_we;

  AST_MASK_FLOOR: assert property (@(posedge clk) disable iff (rst)
    $past(im_rdata[4]) |-> im_rdata[4]); // R5

  AST_SWAP_TO_USER: assert property (@(posedge clk) disable iff (rst)
    (cc_rdata[5] && !$past(cc_rdata[5]) && !$past(stk_wr))
      |-> (sp_rdata == $past(usp_rdata) && ssp_rdata == $past(sp_rdata))); // R6

  AST_SWAP_TO_SYS: assert property (@(posedge clk) disable iff (rst)
    (!cc_rdata[5] && $past(cc_rdata[5]) && !$past(stk_wr))
      |-> (sp_rdata == $past(ssp_rdata) && usp_rdata == $past(sp_rdata))); // R7

  AST_STACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($stable(cc_rdata[5]) && !$past(stk_wr))
      |-> ($stable(sp_rdata) && $stable(ssp_rdata) && $stable(usp_rdata))); // R8

  AST_SYS_ALIAS: assert property (@(posedge clk) disable iff (rst)
    !cc_rdata[5] |-> (ssp_rdata == sp_rdata)); // R9

  AST_USER_ALIAS: assert property (@(posedge clk) disable iff (rst)
    cc_rdata[5] |-> (usp_rdata == sp_rdata)); // R9

  AST_SC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(psw_we || sc_we) |-> $stable(sc_rdata)); // R3
endmodule

bind status_stack_bank status_stack_bank_chk #(.SP_W(SP_W)) u_chk (
  .clk(clk), .rst(rst), .psw_we(psw_we), .sc_we(sc_we),
  .ssp_we(ssp_we), .usp_we(usp_we), .sp_we(sp_we),
  .cc_rdata(cc_rdata), .sc_rdata(sc_rdata), .im_rdata(im_rdata),
  .ssp_rdata(ssp_rdata), .usp_rdata(usp_rdata), .sp_rdata(sp_rdata)
);

// File: tb/status_stack_bank_tb.sv
module status_stack_bank_tb;
  localparam int SP_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic psw_we = 0; logic [31:0] psw_wdata = '0; logic [31:0] psw_rdata;
  logic cc_we = 0;  logic [7:0] cc_wdata = '0;   logic [7:0] cc_rdata;
  logic sc_we = 0;  logic [7:0] sc_wdata = '0;   logic [7:0] sc_rdata;
  logic im_we = 0;  logic [7:0] im_wdata = '0;   logic [7:0] im_rdata;
  logic ssp_we = 0; logic [SP_W-1:0] ssp_wdata = '0; logic [SP_W-1:0] ssp_rdata;
  logic usp_we = 0; logic [SP_W-1:0] usp_wdata = '0; logic [SP_W-1:0] usp_rdata;
  logic sp_we = 0;  logic [SP_W-1:0] sp_wdata = '0;  logic [SP_W-1:0] sp_rdata;

  status_stack_bank #(.SP_W(SP_W)) u_dut (.*);

  int total = 0;
  int fails = 0;
  bit done = 0;

  logic [5:0] m_cc; logic [2:0] m_sc; logic [4:0] m_im;
  logic [SP_W-1:0] m_live, m_u, m_s;

  task automatic chk(input string tag, input string port, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, port, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] epsw;
    epsw = {11'd0, m_im, 5'd0, m_sc, 2'd0, m_cc};
    chk(tag, "psw", psw_rdata, epsw);
    chk(tag, "cc", {24'd0, cc_rdata}, {26'd0, m_cc});
    chk(tag, "sc", {24'd0, sc_rdata}, {29'd0, m_sc});
    chk(tag, "im", {24'd0, im_rdata}, {27'd0, m_im});
    chk(tag, "sp", sp_rdata, m_live);
    chk(tag, "ssp", ssp_rdata, m_cc[5] ? m_s : m_live);
    chk(tag, "usp", usp_rdata, m_cc[5] ? m_live : m_u);
  endtask

  task automatic clear_in();
    psw_we = 0; cc_we = 0; sc_we = 0; im_we = 0; ssp_we = 0; usp_we = 0; sp_we = 0;
  endtask

  task automatic model_reset();
    m_cc = '0; m_sc = '0; m_im = '0; m_live = '0; m_u = '0; m_s = '0;
  endtask

  task automatic do_reset();
    clear_in();
    rst = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  // Inputs are set before the call, at a falling edge.
  task automatic tick(input string tag);
    logic [5:0] ncc; logic [2:0] nsc; logic [4:0] nim, raw; logic imw;
    logic [SP_W-1:0] lv, u, s, nlv, nu, ns;
    logic sel;
    ncc = m_cc; nsc = m_sc; nim = m_im; raw = '0; imw = 0; sel = m_cc[5];
    if (psw_we) begin
      ncc = psw_wdata[5:0]; nsc = psw_wdata[10:8]; raw = psw_wdata[20:16]; imw = 1;
    end else begin
      if (cc_we) ncc = cc_wdata[5:0];
      if (sc_we) nsc = sc_wdata[2:0];
      if (im_we) begin raw = im_wdata[4:0]; imw = 1; end
    end
    if (imw) nim = (m_im >= 16 && raw < 16) ? raw + 5'd16 : raw;
    lv = m_live; u = m_u; s = m_s;
    if (usp_we) begin if (sel) lv = usp_wdata; else u = usp_wdata; end
    if (ssp_we) begin if (!sel) lv = ssp_wdata; else s = ssp_wdata; end
    if (sp_we) lv = sp_wdata;
    nlv = lv; nu = u; ns = s;
    if (sel && !ncc[5]) begin nu = lv; nlv = s; end
    else if (!sel && ncc[5]) begin ns = lv; nlv = u; end
    @(posedge clk);
    m_cc = ncc; m_sc = nsc; m_im = nim; m_live = nlv; m_u = nu; m_s = ns;
    @(negedge clk);
    clear_in();
    check_all(tag);
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    check_all("R1 reset");

    // R2 flag byte sweep
    for (int v = 0; v < 256; v++) begin
      cc_we = 1; cc_wdata = v[7:0]; tick("R2 flag sweep");
    end
    // R3 system-control sweep
    for (int v = 0; v < 256; v++) begin
      sc_we = 1; sc_wdata = v[7:0]; tick("R3 sysctl sweep");
    end
    // R4 status word layout
    for (int k = 0; k < 64; k++) begin
      psw_we = 1; psw_wdata = {k[5:0], k[5:0] ^ 6'h2a, k[3:0], k[5:0], k[1:0] ^ 2'b10, k[5:0] ^ 6'h15, k[1:0]};
      tick("R4 word layout");
    end
    psw_we = 1; psw_wdata = 32'hffff_ffff; tick("R4 all ones");
    psw_we = 1; psw_wdata = 32'h0000_0000; tick("R4 all zeros");

    // R5 mask floor: every current value against every written value
    for (int cur = 0; cur < 32; cur++) begin
      for (int w = 0; w < 32; w++) begin
        do_reset();
        im_we = 1; im_wdata = cur[7:0]; tick("R5 mask setup");
        if (w[0]) begin psw_we = 1; psw_wdata = {11'd0, w[4:0], 16'd0}; end
        else begin im_we = 1; im_wdata = {3'b101, w[4:0]}; end
        tick("R5 mask clamp");
      end
    end

    // Stack directed cases
    do_reset();
    sp_we = 1; sp_wdata = 32'h1111_0000; tick("R9 live write S0");
    usp_we = 1; usp_wdata = 32'h2222_0000; tick("R9 user bank S0");
    ssp_we = 1; ssp_wdata = 32'h3333_0000; tick("R9 sys alias S0");
    cc_we = 1; cc_wdata = 8'h20; tick("R6 swap to user");
    cc_we = 1; cc_wdata = 8'h21; tick("R8 rewrite S1");
    ssp_we = 1; ssp_wdata = 32'h4444_0000; tick("R9 sys bank S1");
    usp_we = 1; usp_wdata = 32'h5555_0000; tick("R9 user alias S1");
    cc_we = 1; cc_wdata = 8'h00; tick("R7 swap to system");
    cc_we = 1; cc_wdata = 8'h0f; tick("R8 rewrite S0");
    // R10 priority
    psw_we = 1; psw_wdata = 32'h0003_0521; cc_we = 1; cc_wdata = 8'h1f;
    sc_we = 1; sc_wdata = 8'h03; im_we = 1; im_wdata = 8'h1e; tick("R10 word wins");
    psw_we = 1; psw_wdata = 32'h0000_0000; cc_we = 1; cc_wdata = 8'h20; tick("R10 word wins swap");
    // R11 same-cycle stack write and swap
    cc_we = 1; cc_wdata = 8'h20; sp_we = 1; sp_wdata = 32'haaaa_0001;
    usp_we = 1; usp_wdata = 32'hbbbb_0002; tick("R11 write then swap up");
    cc_we = 1; cc_wdata = 8'h00; usp_we = 1; usp_wdata = 32'hcccc_0003;
    ssp_we = 1; ssp_wdata = 32'hdddd_0004; tick("R11 write then swap down");
    ssp_we = 1; ssp_wdata = 32'heeee_0005; sp_we = 1; sp_wdata = 32'hffff_0006; tick("R11 live beats alias");

    // Mixed pseudo-random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      psw_we = (r[3:0] == 4'd0);
      psw_wdata = $urandom;
      cc_we = r[4]; cc_wdata = $urandom;
      sc_we = r[5]; sc_wdata = $urandom;
      im_we = r[6]; im_wdata = $urandom;
      ssp_we = r[7]; ssp_wdata = $urandom;
      usp_we = r[8]; usp_wdata = $urandom;
      sp_we = r[9] & r[10]; sp_wdata = $urandom;
      tick("R6 R7 R9 R11 mixed");
    end

    do_reset();
    check_all("R1 reset again");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule